// File: doc/BRIEF.md
# Memory Operand Address Decoder

This block turns the operand-addressing bytes of a variable-length instruction into a decoded memory operand. It takes the mode/register/operand byte, an optional scale-index-base byte and a displacement of 0, 1, 2 or 4 bytes. The bytes come one per cycle from a stream that has a valid flag. Each byte is taken only in a cycle where the block raises `byte_take`. The caller selects 16-bit or 32-bit addressing with `addr32`, and states whether a segment override prefix came before the instruction.

The decoder reads general registers through a single combinational read port (`rf_idx` out, `rf_data` in). It reads one register per cycle: first the base, then the index. It accumulates the effective address, adds the sign-extended displacement, and truncates the sum to 16 bits in 16-bit mode. A one-cycle `done` pulse presents the following results, which hold until the next decode finishes:
- the reg field
- a memory-versus-register flag
- the r/m field
- the effective address
- whether the default segment is the stack segment
- the number of bytes consumed

Register numbering: 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI.

Top module: `modrm_ea_decoder`

## Requirements
- R1: The first byte splits into mode (bits 7:6), reg (bits 5:3) and r/m (bits 2:0). With mode 3, `is_mem` is 0 and `rm_sel` names the second register. The length is 1, `ea` is 0 and `use_ss` is 0.
- R2: In 16-bit mode, r/m values 0..7 address BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX respectively. Each register contributes only its low 16 bits.
- R3: In 16-bit mode, mode 0 with r/m 6 uses no register. The address is a 2-byte direct displacement.
- R4: In 16-bit mode, mode 1 adds a sign-extended 1-byte displacement and mode 2 adds a 2-byte displacement. `ea` bits 31:16 are always 0.
- R5: In 16-bit mode, the stack segment is the default when r/m is 2 or 3, or when r/m is 6 with a nonzero mode. A present segment override clears `use_ss` in every case.
- R6: In 32-bit mode, r/m 4 with a memory mode takes a second byte. Its bits 7:6 give a scale of 1, 2, 4 or 8, bits 5:3 name the index, and bits 2:0 name the base. An index of 4 means no index.
- R7: In that second byte, a base of 5 under mode 0 replaces the base register with a 4-byte displacement. A base of 4 selects the stack segment unless an override is present.
- R8: In 32-bit mode without the second byte, r/m 5 under mode 0 is a bare 4-byte displacement. Under a nonzero mode it adds BP and selects the stack segment unless an override is present.
- R9: In 32-bit mode, mode 1 adds a sign-extended 1-byte displacement and mode 2 adds a 4-byte displacement. The address wraps modulo 2^32.
- R10: Displacement bytes arrive least significant first. `byte_take` is high only while `byte_valid` is high. While the stream is not valid the decode waits with no change to the result.
- R11: `done` is high for exactly one cycle per decode. `length` equals the number of bytes taken, between 1 and 6.
- R12: After reset, `done`, `byte_take`, `ea` and `length` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr32 | input | 1 | 1 selects 32-bit addressing, sampled with the first byte |
| seg_ovr | input | 1 | Segment override present, sampled with the first byte |
| byte_valid | input | 1 | Instruction stream byte is valid |
| byte_data | input | 8 | Instruction stream byte |
| byte_take | output | 1 | Byte accepted this cycle |
| rf_idx | output | 3 | Register file read index |
| rf_data | input | 32 | Register file read data for `rf_idx` |
| done | output | 1 | One-cycle pulse: results are valid |
| is_mem | output | 1 | Operand is in memory |
| reg_field | output | 3 | Reg field of the first byte |
| rm_sel | output | 3 | r/m field (second register when not memory) |
| ea | output | 32 | Effective address |
| use_ss | output | 1 | Default segment is the stack segment |
| length | output | 3 | Bytes consumed by the decode |

## Verification
Assertions check four properties on every cycle:
- `done` never lasts beyond one cycle.
- The reported length stays in 1..6, and a register operand reports length 1 with no stack segment.
- Bytes are taken only when valid, and a stalled displacement holds.
- The upper address half stays clear in 16-bit mode.

The address arithmetic itself can only be shown by the bench's scenarios. These cover:
- every 16-bit register pair and the direct form
- scale-index-base sums with and without base or index
- sign-extended displacements that wrap
- the stack-segment defaults and their suppression by an override
- a stream with gaps giving the same result as a gap-free one

// File: rtl/modrm_ea_pkg.sv
package modrm_ea_pkg;

    localparam int REG_IW = 3;

    localparam logic [REG_IW-1:0] R_SP = 3'd4;
    localparam logic [REG_IW-1:0] R_BP = 3'd5;
    localparam logic [REG_IW-1:0] R_BX = 3'd3;
    localparam logic [REG_IW-1:0] R_SI = 3'd6;
    localparam logic [REG_IW-1:0] R_DI = 3'd7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SIB,
        S_BASE,
        S_INDEX,
        S_DISP,
        S_FIN
    } phase_e;

    // operand plan produced by the byte decoders
    typedef struct packed {
        logic              need_sib;
        logic              has_base;
        logic [REG_IW-1:0] base_r;
        logic              has_index;
        logic [REG_IW-1:0] index_r;
        logic [1:0]        scale;
        logic [2:0]        disp_len;
        logic              ss_cond;
    } plan_t;

    function automatic phase_e after_index(input plan_t p);
        return (p.disp_len != 3'd0) ? S_DISP : S_FIN;
    endfunction

    function automatic phase_e after_base(input plan_t p);
        return p.has_index ? S_INDEX : after_index(p);
    endfunction

    function automatic phase_e after_sib(input plan_t p);
        return p.has_base ? S_BASE : after_base(p);
    endfunction

endpackage

// File: rtl/modrm_ea_field_dec.sv
module modrm_ea_field_dec
    import modrm_ea_pkg::*;
(
    input  logic [7:0] modrm,
    input  logic       wide,
    output plan_t      plan
);
    logic [1:0] md;
    logic [2:0] rm;

    assign md = modrm[7:6];
    assign rm = modrm[2:0];

    always_comb begin
        plan = '0;
        if (!wide) begin
            case (rm)
                3'd0: begin plan.has_base = 1'b1; plan.base_r = R_BX; plan.has_index = 1'b1; plan.index_r = R_SI; end
                3'd1: begin plan.has_base = 1'b1; plan.base_r = R_BX; plan.has_index = 1'b1; plan.index_r = R_DI; end
                3'd2: begin plan.has_base = 1'b1; plan.base_r = R_BP; plan.has_index = 1'b1; plan.index_r = R_SI; end
                3'd3: begin plan.has_base = 1'b1; plan.base_r = R_BP; plan.has_index = 1'b1; plan.index_r = R_DI; end
                3'd4: begin plan.has_base = 1'b1; plan.base_r = R_SI; end
                3'd5: begin plan.has_base = 1'b1; plan.base_r = R_DI; end
                3'd6: begin plan.has_base = (md != 2'd0); plan.base_r = R_BP; end
                default: begin plan.has_base = 1'b1; plan.base_r = R_BX; end
            endcase
            plan.ss_cond = (rm == 3'd2) || (rm == 3'd3) || ((rm == 3'd6) && (md != 2'd0));
            case (md)
                2'd1:    plan.disp_len = 3'd1;
                2'd2:    plan.disp_len = 3'd2;
                default: plan.disp_len = (rm == 3'd6) ? 3'd2 : 3'd0;
            endcase
        end else begin
            if (rm == 3'd4) begin
                plan.need_sib = 1'b1;
            end else if (rm == 3'd5) begin
                plan.has_base = (md != 2'd0);
                plan.base_r   = R_BP;
                plan.ss_cond  = (md != 2'd0);
            end else begin
                plan.has_base = 1'b1;
                plan.base_r   = rm;
            end
            case (md)
                2'd1:    plan.disp_len = 3'd1;
                2'd2:    plan.disp_len = 3'd4;
                default: plan.disp_len = (rm == 3'd5) ? 3'd4 : 3'd0;
            endcase
        end
    end

endmodule

// File: rtl/modrm_ea_sib_dec.sv
module modrm_ea_sib_dec
    import modrm_ea_pkg::*;
(
    input  logic [7:0] sib,
    input  logic [1:0] md,
    output plan_t      plan
);
    logic [2:0] base_f;
    logic [2:0] index_f;

    assign base_f  = sib[2:0];
    assign index_f = sib[5:3];

    always_comb begin
        plan           = '0;
        plan.scale     = sib[7:6];
        plan.index_r   = index_f;
        plan.has_index = (index_f != R_SP);
        plan.base_r    = base_f;
        plan.has_base  = !((base_f == R_BP) && (md == 2'd0));
        plan.ss_cond   = (base_f == R_SP);
        case (md)
            2'd1:    plan.disp_len = 3'd1;
            2'd2:    plan.disp_len = 3'd4;
            default: plan.disp_len = (base_f == R_BP) ? 3'd4 : 3'd0;
        endcase
    end

endmodule

// File: rtl/modrm_ea_decoder.sv
module modrm_ea_decoder
    import modrm_ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr32,
    input  logic          seg_ovr,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    output logic          byte_take,
    output logic [2:0]    rf_idx,
    input  logic [AW-1:0] rf_data,
    output logic          done,
    output logic          is_mem,
    output logic [2:0]    reg_field,
    output logic [2:0]    rm_sel,
    output logic [AW-1:0] ea,
    output logic          use_ss,
    output logic [2:0]    length
);
    localparam int HW = AW / 2;

    typedef struct packed {
        phase_e        st;
        logic          mode32;
        logic          ovr;
        logic [7:0]    modrm;
        plan_t         plan;
        logic [2:0]    len;
        logic [1:0]    dcnt;
        logic [AW-1:0] acc;
        logic [AW-1:0] disp;
        logic          done_o;
        logic          mem_o;
        logic [2:0]    reg_o;
        logic [2:0]    rm_o;
        logic [AW-1:0] ea_o;
        logic          ss_o;
        logic [2:0]    len_o;
    } state_t;

    state_t q, d;
    plan_t  fd_plan, sd_plan, sib_merged;

    modrm_ea_field_dec u_field (
        .modrm (byte_data),
        .wide  (addr32),
        .plan  (fd_plan)
    );

    modrm_ea_sib_dec u_sib (
        .sib  (byte_data),
        .md   (q.modrm[7:6]),
        .plan (sd_plan)
    );

    function automatic logic [AW-1:0] narrow(input logic [AW-1:0] v, input logic w);
        return w ? v : {{(AW-HW){1'b0}}, v[HW-1:0]};
    endfunction

    function automatic logic [AW-1:0] sext(input logic [AW-1:0] v, input logic [2:0] n);
        case (n)
            3'd1:    return {{(AW-8){v[7]}}, v[7:0]};
            3'd2:    return {{(AW-16){v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

    always_comb begin
        sib_merged        = sd_plan;
        sib_merged.need_sib = 1'b0;
    end

    always_comb begin
        d         = q;
        d.done_o  = 1'b0;
        byte_take = 1'b0;
        rf_idx    = '0;
        case (q.st)
            S_IDLE: begin
                if (byte_valid) begin
                    byte_take = 1'b1;
                    d.mode32  = addr32;
                    d.ovr     = seg_ovr;
                    d.modrm   = byte_data;
                    d.plan    = fd_plan;
                    d.len     = 3'd1;
                    d.dcnt    = '0;
                    d.acc     = '0;
                    d.disp    = '0;
                    if (byte_data[7:6] == 2'd3) begin
                        d.plan = '0;
                        d.st   = S_FIN;
                    end else if (fd_plan.need_sib) begin
                        d.st = S_SIB;
                    end else begin
                        d.st = after_sib(fd_plan);
                    end
                end
            end
            S_SIB: begin
                if (byte_valid) begin
                    byte_take = 1'b1;
                    d.len     = 3'(q.len + 3'd1);
                    d.plan    = sib_merged;
                    d.st      = after_sib(sib_merged);
                end
            end
            S_BASE: begin
                rf_idx = q.plan.base_r;
                d.acc  = q.acc + narrow(rf_data, q.mode32);
                d.st   = after_base(q.plan);
            end
            S_INDEX: begin
                rf_idx = q.plan.index_r;
                d.acc  = q.acc + (narrow(rf_data, q.mode32) << q.plan.scale);
                d.st   = after_index(q.plan);
            end
            S_DISP: begin
                if (byte_valid) begin
                    byte_take              = 1'b1;
                    d.disp[8*q.dcnt +: 8]  = byte_data;
                    d.dcnt                 = 2'(q.dcnt + 2'd1);
                    d.len                  = 3'(q.len + 3'd1);
                    if (3'({1'b0, q.dcnt} + 3'd1) == q.plan.disp_len) begin
                        d.st = S_FIN;
                    end
                end
            end
            S_FIN: begin
                d.done_o = 1'b1;
                d.mem_o  = (q.modrm[7:6] != 2'd3);
                d.reg_o  = q.modrm[5:3];
                d.rm_o   = q.modrm[2:0];
                d.ss_o   = q.plan.ss_cond && !q.ovr && (q.modrm[7:6] != 2'd3);
                d.len_o  = q.len;
                d.ea_o   = narrow(q.acc + sext(q.disp, q.plan.disp_len), q.mode32);
                d.st     = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done      = q.done_o;
    assign is_mem    = q.mem_o;
    assign reg_field = q.reg_o;
    assign rm_sel    = q.rm_o;
    assign ea        = q.ea_o;
    assign use_ss    = q.ss_o;
    assign length    = q.len_o;

    logic [AW-1:0] disp_w;
    logic          in_disp_w;
    logic          mode32_w;
    assign disp_w    = q.disp;
    assign in_disp_w = (q.st == S_DISP);
    assign mode32_w  = q.mode32;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (length >= 3'd1) && (length <= 3'd6));

    // R1
    reg_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_mem) |-> (length == 3'd1) && !use_ss);

    // R10
    take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> byte_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_disp_w && !byte_valid) |=> $stable(disp_w));

    // R4
    trunc16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode32_w) |-> (ea[AW-1:HW] == '0));

endmodule

// File: tb/modrm_ea_decoder_bench.sv
module modrm_ea_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    typedef struct packed {
        logic        a32;
        logic        ovr;
        logic [55:0] bytes;
        logic        mem;
        logic [2:0]  rg;
        logic [2:0]  rm;
        logic [31:0] ea;
        logic        ss;
        logic [2:0]  len;
    } vec_t;

    // a32, ovr, stream (first byte lowest), mem, reg, rm, ea, ss, len
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 56'hD8,           1'b0, 3'd3, 3'd0, 32'h0000_0000, 1'b0, 3'd1}, // R1
        '{1'b0, 1'b0, 56'h00,           1'b1, 3'd0, 3'd0, 32'h0000_1000, 1'b0, 3'd1}, // R2
        '{1'b0, 1'b0, 56'hF04A,         1'b1, 3'd1, 3'd2, 32'h0000_7FF0, 1'b1, 3'd2}, // R4 R5
        '{1'b0, 1'b1, 56'hF04A,         1'b1, 3'd1, 3'd2, 32'h0000_7FF0, 1'b0, 3'd2}, // R5
        '{1'b0, 1'b0, 56'h123406,       1'b1, 3'd0, 3'd6, 32'h0000_1234, 1'b0, 3'd3}, // R3
        '{1'b0, 1'b0, 56'h900087,       1'b1, 3'd0, 3'd7, 32'h0000_1000, 1'b0, 3'd3}, // R4
        '{1'b0, 1'b0, 56'h1046,         1'b1, 3'd0, 3'd6, 32'h0000_F010, 1'b1, 3'd2}, // R5
        '{1'b0, 1'b0, 56'h0D,           1'b1, 3'd1, 3'd5, 32'h0000_0044, 1'b0, 3'd1}, // R2
        '{1'b0, 1'b0, 56'h7F5B,         1'b1, 3'd3, 3'd3, 32'h0000_F0C3, 1'b1, 3'd2}, // R2
        '{1'b1, 1'b0, 56'h03,           1'b1, 3'd0, 3'd3, 32'h1234_8000, 1'b0, 3'd1}, // R9
        '{1'b1, 1'b0, 56'h1234567805,   1'b1, 3'd0, 3'd5, 32'h1234_5678, 1'b0, 3'd5}, // R8
        '{1'b1, 1'b0, 56'hFC45,         1'b1, 3'd0, 3'd5, 32'h0020_EFFC, 1'b1, 3'd2}, // R8
        '{1'b1, 1'b0, 56'h8804,         1'b1, 3'd0, 3'd4, 32'h0000_1080, 1'b0, 3'd2}, // R6
        '{1'b1, 1'b0, 56'h00010000F504, 1'b1, 3'd0, 3'd4, 32'h0005_8000, 1'b0, 3'd6}, // R7
        '{1'b1, 1'b0, 56'h000000102484, 1'b1, 3'd0, 3'd4, 32'h0010_0010, 1'b1, 3'd6}, // R7
        '{1'b1, 1'b1, 56'h000000102484, 1'b1, 3'd0, 3'd4, 32'h0010_0010, 1'b0, 3'd6}, // R7
        '{1'b1, 1'b0, 56'hFFFFFFFF6084, 1'b1, 3'd0, 3'd4, 32'h0000_0FFF, 1'b0, 3'd6}, // R6 R9
        '{1'b1, 1'b0, 56'hF9,           1'b0, 3'd7, 3'd1, 32'h0000_0000, 1'b0, 3'd1}, // R1
        '{1'b1, 1'b0, 56'hFFFFF00086,   1'b1, 3'd0, 3'd6, 32'h0000_8000, 1'b0, 3'd5}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr32 = 1'b0;
    logic        seg_ovr = 1'b0;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_take;
    logic [2:0]  rf_idx;
    logic [31:0] rf_data;
    logic        done;
    logic        is_mem;
    logic [2:0]  reg_field;
    logic [2:0]  rm_sel;
    logic [31:0] ea;
    logic        use_ss;
    logic [2:0]  length;

    int checks = 0;
    int errors = 0;

    logic [31:0] rf [8];
    logic [55:0] stream = '0;
    int          base_p = 0;
    int          p = 0;
    int          slen = 0;
    logic        active = 1'b0;
    logic        gap_en = 1'b0;
    logic        tick = 1'b0;
    int          bad_take = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        rf[0] = 32'h0000_1000; rf[1] = 32'h0000_0020;
        rf[2] = 32'h0000_0300; rf[3] = 32'h1234_8000;
        rf[4] = 32'h0010_0000; rf[5] = 32'h0020_F000;
        rf[6] = 32'h0000_9000; rf[7] = 32'h0000_0044;
    end

    assign rf_data    = rf[rf_idx];
    assign byte_valid = active && ((p - base_p) < slen) && !(gap_en && tick);
    assign byte_data  = stream[8*((p - base_p) & 7) +: 8];

    always @(posedge clk) begin
        tick <= ~tick;
        if (byte_take) p <= p + 1;
    end

    always @(negedge clk) begin
        if (byte_take && !byte_valid) bad_take = bad_take + 1;
    end

    modrm_ea_decoder u_modrm_ea_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr32     (addr32),
        .seg_ovr    (seg_ovr),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_take  (byte_take),
        .rf_idx     (rf_idx),
        .rf_data    (rf_data),
        .done       (done),
        .is_mem     (is_mem),
        .reg_field  (reg_field),
        .rm_sel     (rm_sel),
        .ea         (ea),
        .use_ss     (use_ss),
        .length     (length)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        bit seen;
        seen = 1'b0;
        @(negedge clk);
        addr32 = v.a32;
        seg_ovr = v.ovr;
        stream = v.bytes;
        slen = int'(v.len);
        base_p = p;
        active = 1'b1;
        for (int c = 0; c < 80 && !seen; c++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        active = 1'b0;
        chk(seen, $sformatf("R11 vec%0d done seen", idx), {31'd0, seen}, 32'd1);
        if (seen) begin
            chk(is_mem == v.mem, $sformatf("R1 vec%0d is_mem", idx), {31'd0, is_mem}, {31'd0, v.mem});
            chk(reg_field == v.rg, $sformatf("R1 vec%0d reg", idx), {29'd0, reg_field}, {29'd0, v.rg});
            chk(rm_sel == v.rm, $sformatf("R1 vec%0d rm", idx), {29'd0, rm_sel}, {29'd0, v.rm});
            chk(ea == v.ea, $sformatf("R2 R3 R4 R6 R7 R8 R9 vec%0d ea", idx), ea, v.ea);
            chk(use_ss == v.ss, $sformatf("R5 R7 R8 vec%0d ss", idx), {31'd0, use_ss}, {31'd0, v.ss});
            chk(length == v.len, $sformatf("R11 vec%0d length", idx), {29'd0, length}, {29'd0, v.len});
            chk((p - base_p) == slen, $sformatf("R11 vec%0d bytes taken", idx), p - base_p, slen);
            @(negedge clk);
            chk(done == 1'b0, $sformatf("R11 vec%0d single pulse", idx), {31'd0, done}, 32'd0);
            chk(ea == v.ea, $sformatf("R11 vec%0d result held", idx), ea, v.ea);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors = errors + 1;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(done == 1'b0, "R12 done after reset", {31'd0, done}, 32'd0);
        chk(byte_take == 1'b0, "R12 take after reset", {31'd0, byte_take}, 32'd0);
        chk(ea == 32'd0, "R12 ea after reset", ea, 32'd0);
        chk(length == 3'd0, "R12 length after reset", {29'd0, length}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R10 stream with gaps must give identical results
        gap_en = 1'b1;
        run_vec(VECS[13], 100);
        run_vec(VECS[5], 101);
        run_vec(VECS[18], 102);
        gap_en = 1'b0;

        // R10 stall with no valid byte: nothing is taken, no completion
        @(negedge clk);
        addr32 = 1'b1;
        seg_ovr = 1'b0;
        stream = 56'h1234567805;
        slen = 1;
        base_p = p;
        active = 1'b1;
        @(negedge clk);
        active = 1'b0;
        repeat (5) @(negedge clk);
        chk(done == 1'b0, "R10 stalled in displacement no done", {31'd0, done}, 32'd0);
        chk(byte_take == 1'b0, "R10 no take without valid", {31'd0, byte_take}, 32'd0);
        stream = 56'h12345678;
        slen = 4;
        base_p = p;
        active = 1'b1;
        for (int c = 0; c < 40 && !done; c++) @(negedge clk);
        active = 1'b0;
        chk(ea == 32'h1234_5678, "R10 resumed little-endian displacement", ea, 32'h1234_5678);
        chk(length == 3'd5, "R10 resumed length", {29'd0, length}, 32'd5);

        chk(bad_take == 0, "R10 take only with valid", bad_take, 32'd0);

        // R12 reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ea == 32'd0, "R12 ea cleared by reset", ea, 32'd0);
        chk(length == 3'd0, "R12 length cleared by reset", {29'd0, length}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule